// File: doc/BRIEF.md
# Command-List Control Register Bank

This block is the register bank that software uses to steer a graphics command processor through a command list held in memory. It sits on a 32-bit bus and decodes one word per access. Every write carries a per-bit enable mask. The bank holds three command-buffer pointers: start, end and current. The start and end pointers can be written, and all three are driven out to the command processor. A status word collects three software flags and eight live condition bits. Four counter values arrive from outside and can be read back.

Writing the end pointer tells the command processor to fetch, through a one-cycle kick pulse. The status word is never written directly. A status write is a set of commands: paired clear and set bits for each flag, plus clear strobes for the four external counters. When a status write releases the freeze flag, a one-cycle resume pulse goes to a neighbouring signal processor, but only if that processor reports that it is neither halted nor stopped at a break.

Top module: `cmdlist_ctrl_regs`

## Requirements
- R1: While synchronous active-high reset `rst` is high at a clock edge, the three pointers and the three status flags clear to zero, and `cmdKick`, `spResume`, the four counter-clear outputs and `busRdErr` are low after that edge.
- R2: A write to word offset 0x00 loads `busWrData & busWrMask` into both `startPtr` and `curPtr`. Both values are visible after the clock edge that samples the write.
- R3: A write to word offset 0x04 loads `busWrData & busWrMask` into `endPtr` and raises `cmdKick` for exactly the one cycle after the sampling edge.
- R4: A write to word offset 0x08 changes nothing. `startPtr`, `endPtr`, `curPtr` and the status flags keep their values, and `cmdKick` stays low.
- R5: On a status write (offset 0x0C), each masked command pair acts on one flag: command bits 0/1 clear/set flag 0 (DMA source), bits 2/3 clear/set flag 1 (freeze), and bits 4/5 clear/set flag 2 (flush). When both bits of a pair are 1, the flag ends up set.
- R6: `spResume` is high for the one cycle after a status write whose masked command bit 2 is 1, and only if `spHalted` and `spBroke` were both low when the write was sampled.
- R7: In a status write, masked command bits 6, 7, 8 and 9 each raise a one-cycle pulse, in that order, on `clrTmemCnt`, `clrPipeCnt`, `clrCmdCnt` and `clrClockCnt`.
- R8: Write data bits whose mask bit is 0 have no effect. A status write with an all-zero mask changes no flag and raises no pulse.
- R9: A read is answered in the cycle after it is sampled. Offset 0x0C returns the flags in bits 2:0, `liveStatus[7:0]` in bits 10:3 and zero above. Offsets 0x10, 0x14, 0x18 and 0x1C return `clockCount`, `bufBusyCount`, `pipeBusyCount` and `tmemCount`, in that order.
- R10: A read of offset 0x00, 0x04 or 0x08, or of any address outside the 32-byte window, returns zero with `busRdErr` high for that cycle.
- R11: The top three address bits do not take part in decode. An address and the same address with bits 31:29 changed reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Write request, sampled on the rising edge |
| busRdEn | input | 1 | Read request, sampled on the rising edge |
| busAddr | input | 32 | Byte address of the access |
| busWrData | input | 32 | Write data |
| busWrMask | input | 32 | Per-bit write enable |
| busRdData | output | 32 | Read data, valid in the cycle after the read |
| busRdErr | output | 1 | One-cycle flag: the read hit a non-readable offset |
| spHalted | input | 1 | Signal processor reports halted |
| spBroke | input | 1 | Signal processor reports stopped at a break |
| liveStatus | input | 8 | Live condition bits, reported at status bits 10:3 |
| clockCount | input | 32 | Clock counter value |
| bufBusyCount | input | 32 | Buffer-busy counter value |
| pipeBusyCount | input | 32 | Pipe-busy counter value |
| tmemCount | input | 32 | Texture-memory counter value |
| startPtr | output | 32 | Command-buffer start pointer |
| endPtr | output | 32 | Command-buffer end pointer |
| curPtr | output | 32 | Command-buffer current pointer |
| cmdKick | output | 1 | One-cycle pulse after an end-pointer write |
| spResume | output | 1 | One-cycle pulse that restarts the signal processor |
| clrTmemCnt | output | 1 | One-cycle clear for the texture-memory counter |
| clrPipeCnt | output | 1 | One-cycle clear for the pipe counter |
| clrCmdCnt | output | 1 | One-cycle clear for the command counter |
| clrClockCnt | output | 1 | One-cycle clear for the clock counter |

## Verification
The bench loads each of the eight states of the three flags in turn. From each state it applies all 64 patterns of the six pair command bits, and it varies the halt and break inputs as it goes. This catches a design that lets clear win when both bits of a pair are set, or that sends a resume pulse while the processor is halted or broken. Masked writes with several mask patterns would expose a design that ignores the mask or applies it only to pointer writes. A write to the current offset, and an aliased address with the top bits set, would catch a design that stores the current pointer or decodes all 32 address bits. Reads of the write-only offsets and of an address just past the window must return zero and raise the error flag, rather than returning stale pointer data.

// File: rtl/cl_regs_pkg.sv
package cl_regs_pkg;
  // Word index inside the 32-byte window; the order is the address map.
  typedef enum logic [2:0] {
    IDX_START    = 3'd0,
    IDX_END      = 3'd1,
    IDX_CUR      = 3'd2,
    IDX_STATUS   = 3'd3,
    IDX_CLOCK    = 3'd4,
    IDX_BUFBUSY  = 3'd5,
    IDX_PIPEBUSY = 3'd6,
    IDX_TMEM     = 3'd7
  } regIdx_t;

  localparam int NUM_FLAGS = 3;   // dma source, freeze, flush
  localparam int CMD_W     = 10;  // status-write command bits
  localparam int CMD_FREEZE_CLR = 2;
  localparam int CMD_CTR_LO     = 6;  // first counter-clear command bit
  localparam int NUM_CTR        = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    ldStart;
    logic    ldEnd;
    logic    stsWr;
    logic    rdLive;
    logic    rdErr;
    regIdx_t rdIdx;
  } clStrobe_t;
endpackage

// File: rtl/cl_regs_ctrl.sv
module cl_regs_ctrl
  import cl_regs_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] BASE_ADDR   = 32'h0410_0000,
  parameter logic [31:0] DECODE_MASK = 32'h1FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CMD_W-1:0]  cmdBits,
  input  logic              spHalted,
  input  logic              spBroke,
  output clStrobe_t         strb,
  output logic              cmdKick,
  output logic              spResume,
  output logic [NUM_CTR-1:0] ctrClr
);
  localparam int          WIN_LSB = 5;
  localparam logic [31:0] BASE_M  = BASE_ADDR & DECODE_MASK;

  logic [ADDR_W-1:0] phys;
  logic              inWin;
  regIdx_t           idx;
  logic [1:0]        addrUnused;

  assign phys       = busAddr & DECODE_MASK[ADDR_W-1:0];
  assign inWin      = (phys[ADDR_W-1:WIN_LSB] == BASE_M[ADDR_W-1:WIN_LSB]);
  assign idx        = regIdx_t'(phys[WIN_LSB-1:2]);
  assign addrUnused = phys[1:0];

  always_comb begin
    strb         = '0;
    strb.ldStart = busWrEn && inWin && (idx == IDX_START);
    strb.ldEnd   = busWrEn && inWin && (idx == IDX_END);
    strb.stsWr   = busWrEn && inWin && (idx == IDX_STATUS);
    strb.rdLive  = busRdEn && inWin && (idx >= IDX_STATUS);
    strb.rdErr   = busRdEn && !strb.rdLive;
    strb.rdIdx   = idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdKick  <= 1'b0;
      spResume <= 1'b0;
      ctrClr   <= '0;
    end else begin
      cmdKick  <= strb.ldEnd;
      spResume <= strb.stsWr && cmdBits[CMD_FREEZE_CLR] && !spHalted && !spBroke;
      ctrClr   <= strb.stsWr ? cmdBits[CMD_CTR_LO +: NUM_CTR] : '0;
    end
  end

  // R3
  kick_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmdKick |-> $past(busWrEn));
  // R6
  resume_gate_chk: assert property (@(posedge clk) disable iff (rst)
    spResume |-> ($past(!spHalted) && $past(!spBroke) && $past(busWrEn)));
  // R7
  ctr_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrClr != '0) |-> $past(busWrEn));
endmodule

// File: rtl/cl_regs_dp.sv
module cl_regs_dp
  import cl_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIVE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  clStrobe_t         strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busWrMask,
  input  logic [LIVE_W-1:0] liveStatus,
  input  logic [DATA_W-1:0] clockCount,
  input  logic [DATA_W-1:0] bufBusyCount,
  input  logic [DATA_W-1:0] pipeBusyCount,
  input  logic [DATA_W-1:0] tmemCount,
  output logic [DATA_W-1:0] startPtr,
  output logic [DATA_W-1:0] endPtr,
  output logic [DATA_W-1:0] curPtr,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdErr
);
  localparam int PAD_W = DATA_W - NUM_FLAGS - LIVE_W;

  logic [DATA_W-1:0]    wrVal;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flagsNext;
  logic [DATA_W-1:0]    statusWord;
  logic [DATA_W-1:0]    rdMux;

  assign wrVal = busWrData & busWrMask;

  // Clear applied first, set second: set wins.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flagsNext[i] = strb.stsWr
                        ? ((flags[i] & ~wrVal[2*i]) | wrVal[2*i+1])
                        : flags[i];
  end

  assign statusWord = {{PAD_W{1'b0}}, liveStatus, flags};

  always_comb begin
    case (strb.rdIdx)
      IDX_STATUS:   rdMux = statusWord;
      IDX_CLOCK:    rdMux = clockCount;
      IDX_BUFBUSY:  rdMux = bufBusyCount;
      IDX_PIPEBUSY: rdMux = pipeBusyCount;
      IDX_TMEM:     rdMux = tmemCount;
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startPtr  <= '0;
      endPtr    <= '0;
      curPtr    <= '0;
      flags     <= '0;
      busRdData <= '0;
      busRdErr  <= 1'b0;
    end else begin
      if (strb.ldStart) begin
        startPtr <= wrVal;
        curPtr   <= wrVal;
      end
      if (strb.ldEnd) endPtr <= wrVal;
      flags     <= flagsNext;
      busRdData <= strb.rdLive ? rdMux : '0;
      busRdErr  <= strb.rdErr;
    end
  end

  // R2
  cur_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    strb.ldStart |=> (curPtr == startPtr));
  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.stsWr |=> $stable(flags));
  // R10
  err_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    busRdErr |-> (busRdData == '0));
  // R4
  start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.ldStart |=> ($stable(startPtr) && $stable(curPtr)));
endmodule

// File: rtl/cmdlist_ctrl_regs.sv
module cmdlist_ctrl_regs
  import cl_regs_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          LIVE_W      = 8,
  parameter logic [31:0] BASE_ADDR   = 32'h0410_0000,
  parameter logic [31:0] DECODE_MASK = 32'h1FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busWrMask,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdErr,
  input  logic              spHalted,
  input  logic              spBroke,
  input  logic [LIVE_W-1:0] liveStatus,
  input  logic [DATA_W-1:0] clockCount,
  input  logic [DATA_W-1:0] bufBusyCount,
  input  logic [DATA_W-1:0] pipeBusyCount,
  input  logic [DATA_W-1:0] tmemCount,
  output logic [DATA_W-1:0] startPtr,
  output logic [DATA_W-1:0] endPtr,
  output logic [DATA_W-1:0] curPtr,
  output logic              cmdKick,
  output logic              spResume,
  output logic              clrTmemCnt,
  output logic              clrPipeCnt,
  output logic              clrCmdCnt,
  output logic              clrClockCnt
);
  clStrobe_t          strb;
  logic [CMD_W-1:0]   cmdBits;
  logic [NUM_CTR-1:0] ctrClr;

  assign cmdBits = busWrData[CMD_W-1:0] & busWrMask[CMD_W-1:0];

  cl_regs_ctrl #(
    .ADDR_W(32), .BASE_ADDR(BASE_ADDR), .DECODE_MASK(DECODE_MASK)
  ) ctrl_i (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .cmdBits(cmdBits), .spHalted(spHalted),
    .spBroke(spBroke), .strb(strb), .cmdKick(cmdKick),
    .spResume(spResume), .ctrClr(ctrClr)
  );

  cl_regs_dp #(.DATA_W(DATA_W), .LIVE_W(LIVE_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .busWrData(busWrData),
    .busWrMask(busWrMask), .liveStatus(liveStatus),
    .clockCount(clockCount), .bufBusyCount(bufBusyCount),
    .pipeBusyCount(pipeBusyCount), .tmemCount(tmemCount),
    .startPtr(startPtr), .endPtr(endPtr), .curPtr(curPtr),
    .busRdData(busRdData), .busRdErr(busRdErr)
  );

  assign clrTmemCnt  = ctrClr[0];
  assign clrPipeCnt  = ctrClr[1];
  assign clrCmdCnt   = ctrClr[2];
  assign clrClockCnt = ctrClr[3];

  // R1
  pulses_quiet_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cmdKick && !spResume && !busRdErr && (ctrClr == '0)));
endmodule

// File: tb/cmdlist_ctrl_regs_tb_top.sv
module cmdlist_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busAddr = '0, busWrData = '0, busWrMask = '0;
  logic [31:0] busRdData;
  logic        busRdErr;
  logic        spHalted = 1'b0, spBroke = 1'b0;
  logic [7:0]  liveStatus = '0;
  logic [31:0] clockCount = 32'h1111_0001, bufBusyCount = 32'h2222_0002;
  logic [31:0] pipeBusyCount = 32'h3333_0003, tmemCount = 32'h4444_0004;
  logic [31:0] startPtr, endPtr, curPtr;
  logic        cmdKick, spResume, clrTmemCnt, clrPipeCnt, clrCmdCnt, clrClockCnt;

  int total = 0;
  int fails = 0;

  localparam logic [31:0] BASE = 32'h0410_0000;

  always #2 clk = ~clk;

  cmdlist_ctrl_regs dut_i (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busWrMask(busWrMask),
    .busRdData(busRdData), .busRdErr(busRdErr), .spHalted(spHalted),
    .spBroke(spBroke), .liveStatus(liveStatus), .clockCount(clockCount),
    .bufBusyCount(bufBusyCount), .pipeBusyCount(pipeBusyCount),
    .tmemCount(tmemCount), .startPtr(startPtr), .endPtr(endPtr),
    .curPtr(curPtr), .cmdKick(cmdKick), .spResume(spResume),
    .clrTmemCnt(clrTmemCnt), .clrPipeCnt(clrPipeCnt),
    .clrCmdCnt(clrCmdCnt), .clrClockCnt(clrClockCnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Outputs sampled at the negedge after the sampling posedge.
  task automatic busWrite(input logic [31:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busWrMask = m;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [31:0] a);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [3:0] pulses();
    return {clrClockCnt, clrCmdCnt, clrPipeCnt, clrTmemCnt};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [2:0]  expFlags;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 startPtr", startPtr, 0);
    check("R1 endPtr", endPtr, 0);
    check("R1 curPtr", curPtr, 0);
    check("R1 pulses", {27'd0, cmdKick, spResume, pulses() != 0, busRdErr}, 0);
    busRead(BASE + 32'h0C);
    check("R1 status flags", busRdData & 32'h7, 0);

    // R2 / R8 start writes with several masks
    for (int k = 0; k < 6; k++) begin
      logic [31:0] d, m;
      d = 32'hA5A5_0000 ^ (32'h1357_9BDF * k);
      m = (k == 0) ? 32'hFFFF_FFFF : (32'h0F0F_F0F0 << k);
      busWrite(BASE + 32'h00, d, m);
      check("R2 startPtr masked", startPtr, d & m);
      check("R2 curPtr reload", curPtr, d & m);
      check("R3 no kick on start", {31'd0, cmdKick}, 0);
    end

    // R3 end write and kick
    busWrite(BASE + 32'h04, 32'hDEAD_BEEF, 32'hFFFF_00FF);
    check("R3 endPtr", endPtr, 32'hDEAD_00EF);
    check("R3 kick high", {31'd0, cmdKick}, 1);
    @(negedge clk);
    check("R3 kick one cycle", {31'd0, cmdKick}, 0);

    // R4 current offset ignored
    v = curPtr;
    busWrite(BASE + 32'h08, 32'h1234_5678, 32'hFFFF_FFFF);
    check("R4 curPtr unchanged", curPtr, v);
    check("R4 endPtr unchanged", endPtr, 32'hDEAD_00EF);
    check("R4 no kick", {31'd0, cmdKick}, 0);

    // R11 alias with top address bits set
    busWrite(BASE | 32'hE000_0000, 32'h0000_4000, 32'hFFFF_FFFF);
    check("R11 aliased start", startPtr, 32'h0000_4000);
    busWrite((BASE + 32'h04) | 32'hA000_0000, 32'h0000_8000, 32'hFFFF_FFFF);
    check("R11 aliased end", endPtr, 32'h0000_8000);

    // R5 / R6 / R7 sweep: every prior flag state, every pair command.
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 64; c++) begin
        logic [31:0] pre, cmd;
        logic [3:0]  ctrBits;
        pre = 32'h15;
        for (int i = 0; i < 3; i++) if (p[i]) pre = pre | (32'h2 << (2*i));
        busWrite(BASE + 32'h0C, pre, 32'hFFFF_FFFF);
        ctrBits  = 4'(c ^ p);
        cmd      = 32'(c) | (32'(ctrBits) << 6) | 32'hFFFF_F000;
        spHalted = c[3] & p[0];
        spBroke  = c[4] & p[1];
        busWrite(BASE + 32'h0C, cmd, 32'hFFFF_FFFF);
        check("R6 resume", {31'd0, spResume},
              {31'd0, (c[2] && !spHalted && !spBroke)});
        check("R7 counter clears", {28'd0, pulses()}, {28'd0, ctrBits});
        for (int i = 0; i < 3; i++)
          expFlags[i] = (p[i] & ~c[2*i]) | c[2*i+1];
        liveStatus = 8'(p * 37 + c);
        busRead(BASE + 32'h0C);
        check("R5 status flags", busRdData,
              {21'd0, liveStatus, expFlags});
      end
    end
    spHalted = 1'b0; spBroke = 1'b0;

    // R8 zero mask: no flag change, no pulse
    busWrite(BASE + 32'h0C, 32'h15, 32'hFFFF_FFFF);
    busWrite(BASE + 32'h0C, 32'h3FF, 32'h0);
    check("R8 no resume", {31'd0, spResume}, 0);
    check("R8 no clears", {28'd0, pulses()}, 0);
    busRead(BASE + 32'h0C);
    check("R8 flags held", busRdData & 32'h7, 0);
    busWrite(BASE + 32'h0C, 32'h3F, 32'h0000_0022);
    busRead(BASE + 32'h0C);
    check("R8 partial mask", busRdData & 32'h7, 32'h5);

    // R9 counter reads
    busRead(BASE + 32'h10); check("R9 clock", busRdData, clockCount);
    check("R9 no err", {31'd0, busRdErr}, 0);
    busRead(BASE + 32'h14); check("R9 bufbusy", busRdData, bufBusyCount);
    busRead(BASE + 32'h18); check("R9 pipebusy", busRdData, pipeBusyCount);
    busRead((BASE + 32'h1C) | 32'h2000_0000);
    check("R9 tmem aliased", busRdData, tmemCount);

    // R10 non-readable offsets
    for (int o = 0; o < 4; o++) begin
      logic [31:0] a;
      a = (o == 3) ? BASE + 32'h20 : BASE + 32'(4 * o);
      busRead(a);
      check("R10 zero data", busRdData, 0);
      check("R10 err flag", {31'd0, busRdErr}, 1);
    end
    @(negedge clk);
    check("R10 err one cycle", {31'd0, busRdErr}, 0);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears pointers", startPtr | endPtr | curPtr, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule